// File: doc/BRIEF.md
# CAN Transmit Buffer Scheduler

This block owns the transmit element region of a CAN controller and decides which stored message goes on the wire next. The region holds a fixed number of elements, split at run time into two parts. The first part is a set of dedicated buffers that the host fills and arms one by one. The second part is a shared pool. The host pushes messages into the pool, and the pool is served either in write order or lowest identifier first. A protocol engine asks for the current winner with a start pulse. It then takes the payload as a byte stream and reports the end of the frame with a completion pulse.

The element store is modelled as a plain register array. Each selected element is reported with its index and its word address. The address follows from the configured region base and the configured per-element data size. Payload bytes that the configured data field cannot hold are filled with a fixed pad value. Configuration is taken over only while the host holds the block in its init state and nothing is armed or in flight.

Top module: `can_tx_sched`

## Requirements
- R1: Dedicated buffers take indices 0 to D-1 and pool slots take D to D+P-1. D is the configured dedicated count, clamped to 8. P is the configured pool count, clamped to 8-D. The reported address is base + index*(2 + ceil(F/4)), where F is the configured field size in bytes, clamped to 8.
- R2: In write-order pool mode (`cfg_queue_mode`=0), only the oldest armed pool slot competes. Pool messages leave in push order, even when they share an identifier.
- R3: In queue mode (`cfg_queue_mode`=1), every armed pool slot competes. A push goes to the lowest-indexed free pool slot.
- R4: A dedicated buffer is armed only by `req_en` with `req_idx` < D while `cfg_init` is 0. A request outside that range, or one made during init, has no effect. A written but unarmed buffer is never selected.
- R5: Among all competing elements, the one with the numerically lowest 11-bit identifier is selected. On equal identifiers the lower index wins.
- R6: After an accepted start, the block streams min(DLC,8) bytes, one per cycle, beginning the cycle after the start. Byte k is data bits [8k+7:8k] when k < F, and 8'hCC otherwise. `byte_last` marks the final byte.
- R7: The pool tracks its fill level in `pool_level`. `pool_full` is 1 whenever the level equals P, which includes P=0. A push made while full is refused and changes nothing.
- R8: `tx_start` is taken only when `sel_valid` is 1 and no frame is in flight. `tx_done` clears the armed state of the in-flight element, ends its stream, and in write-order mode advances the pool read position.
- R9: `cancel_en` disarms the dedicated buffer `cancel_idx` < D, unless that buffer is the one in flight. A cancel in the same cycle as a request for the same buffer wins.
- R10: The configuration inputs are copied into the block on every cycle in which `cfg_init` is 1, nothing is armed and nothing is in flight. At all other times they are ignored.
- R11: A pool push and a pool completion in the same cycle both take effect when the pool was not full before that cycle, so the level stays unchanged. When the pool was full, the push is refused and the level drops by one.
- R12: After reset nothing is armed and nothing is in flight: `sel_valid`=0, `byte_valid`=0, `pool_level`=0. No pool slots are configured, so `pool_full`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_init | input | 1 | Init state; enables configuration capture |
| cfg_start_addr | input | 16 | Region base word address |
| cfg_ded_num | input | 4 | Number of dedicated buffers |
| cfg_pool_num | input | 4 | Number of pool slots |
| cfg_queue_mode | input | 1 | 0 write-order pool, 1 lowest-identifier pool |
| cfg_field_bytes | input | 4 | Data field size per element in bytes |
| wr_ded_en | input | 1 | Write a dedicated buffer |
| wr_ded_idx | input | 3 | Dedicated buffer to write |
| wr_pool_en | input | 1 | Push a message into the pool (arms it) |
| wr_id | input | 11 | Identifier of the written message |
| wr_dlc | input | 4 | Data length code of the written message |
| wr_data | input | 64 | Payload, byte k in bits [8k+7:8k] |
| req_en | input | 1 | Arm a dedicated buffer |
| req_idx | input | 3 | Dedicated buffer to arm |
| cancel_en | input | 1 | Disarm a dedicated buffer |
| cancel_idx | input | 3 | Dedicated buffer to disarm |
| tx_start | input | 1 | Engine takes the selected element |
| tx_done | input | 1 | Engine finished the in-flight element |
| sel_valid | output | 1 | A candidate is selected |
| sel_idx | output | 3 | Index of the selected element |
| sel_addr | output | 16 | Word address of the selected element |
| byte_valid | output | 1 | Stream byte present |
| byte_data | output | 8 | Stream byte, payload or pad |
| byte_last | output | 1 | Final byte of the stream |
| pool_full | output | 1 | Pool fill level equals its size |
| pool_level | output | 4 | Pool fill level |

## Verification
Two same-cycle collisions matter here. The first is a pool push arriving in the same cycle as the completion that frees a pool slot. The bench fills a two-slot pool, sends one frame, and pulses `tx_done` together with `wr_pool_en`. The push must be refused, because the pool was full before that edge, and the level must fall to one. The bench then repeats the collision with one slot free. This time the level must hold, and the pushed message must come out after the older one. The second collision is a request and a cancel for the same buffer. Beside it, the bench checks that a cancel aimed at the in-flight buffer leaves that buffer selected.

// File: rtl/can_tx_pkg.sv
package can_tx_pkg;

    localparam int NELEM     = 8;
    localparam int IDX_W     = $clog2(NELEM);
    localparam int CNT_W     = $clog2(NELEM + 1);
    localparam int ID_W      = 11;
    localparam int ADDR_W    = 16;
    localparam int MAX_BYTES = 8;
    localparam int DATA_W    = MAX_BYTES * 8;
    localparam int DLC_W     = 4;
    localparam int HDR_WORDS = 2;
    localparam logic [7:0] PAD_BYTE = 8'hCC;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [DLC_W-1:0]  dlc;
        logic [DATA_W-1:0] data;
    } tx_elem_t;

    typedef struct packed {
        logic [ADDR_W-1:0] start;
        logic [CNT_W-1:0]  ded;
        logic [CNT_W-1:0]  pool;
        logic              queue;
        logic [DLC_W-1:0]  field;
    } tx_cfg_t;

    function automatic logic [DLC_W-1:0] clamp_bytes(input logic [DLC_W-1:0] n);
        return (int'(n) > MAX_BYTES) ? DLC_W'(MAX_BYTES) : n;
    endfunction

    function automatic logic [ADDR_W-1:0] elem_words(input logic [DLC_W-1:0] field);
        logic [DLC_W:0] f;
        f = {1'b0, clamp_bytes(field)} + (DLC_W+1)'(3);
        return ADDR_W'(HDR_WORDS) + ADDR_W'(f >> 2);
    endfunction

endpackage

// File: rtl/can_tx_arb.sv
module can_tx_arb #(
    parameter int N    = 8,
    parameter int ID_W = 11,
    localparam int IW  = $clog2(N)
) (
    input  logic [N-1:0]           cand,
    input  logic [N-1:0][ID_W-1:0] ids,
    output logic                   found,
    output logic [IW-1:0]          win
);
    logic [ID_W-1:0] best;

    // strict less-than keeps the lower index on equal identifiers
    always_comb begin
        found = 1'b0;
        win   = '0;
        best  = '1;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!found || ids[i] < best)) begin
                found = 1'b1;
                win   = IW'(i);
                best  = ids[i];
            end
        end
    end
endmodule

// File: rtl/can_tx_pool.sv
module can_tx_pool #(
    parameter int N     = 8,
    localparam int IW   = $clog2(N),
    localparam int CW   = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] size,
    input  logic          queue,
    input  logic [N-1:0]  free_rel,
    input  logic          push,
    input  logic          pop,
    output logic [IW-1:0] put_rel,
    output logic [IW-1:0] get_rel,
    output logic [CW-1:0] level,
    output logic          full
);
    logic [IW-1:0] put_ptr, get_ptr, first_free;
    logic          push_ok;

    function automatic logic [IW-1:0] wrap_inc(input logic [IW-1:0] p, input logic [CW-1:0] sz);
        return (CW'(p) + CW'(1) >= sz) ? '0 : p + IW'(1);
    endfunction

    always_comb begin
        first_free = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free_rel[i]) first_free = IW'(i);
        end
    end

    assign full    = (level >= size);
    assign push_ok = push && !full;
    assign put_rel = queue ? first_free : put_ptr;
    assign get_rel = get_ptr;

    always_ff @(posedge clk) begin
        if (rst || load) begin
            put_ptr <= '0;
            get_ptr <= '0;
            level   <= '0;
        end else begin
            if (push_ok && !queue) put_ptr <= wrap_inc(put_ptr, size);
            if (pop && !queue)     get_ptr <= wrap_inc(get_ptr, size);
            case ({push_ok, pop})
                2'b10:   level <= level + CW'(1);
                2'b01:   level <= level - CW'(1);
                default: level <= level;
            endcase
        end
    end

    assert_level_bound_R7: assert property (@(posedge clk) disable iff (rst)
        level <= size);

    assert_full_refuse_R7: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop && !load) |=> $stable(level));

    assert_push_pop_level_R11: assert property (@(posedge clk) disable iff (rst)
        (push && !full && pop && !load) |=> $stable(level));
endmodule

// File: rtl/can_tx_stream.sv
module can_tx_stream
    import can_tx_pkg::*;
#(
    parameter int NB   = MAX_BYTES,
    localparam int CW  = $clog2(NB + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              abort,
    input  logic [DLC_W-1:0]  start_dlc,
    input  logic [DLC_W-1:0]  field,
    input  logic [NB*8-1:0]   data,
    output logic              valid,
    output logic [7:0]        byte_out,
    output logic              last
);
    logic          active;
    logic [CW-1:0] cnt, len;
    logic [CW-1:0] fld;

    assign fld      = CW'(clamp_bytes(field));
    assign valid    = active;
    assign last     = active && (cnt == len - CW'(1));
    assign byte_out = (cnt < fld) ? data[8*int'(cnt) +: 8] : PAD_BYTE;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
            len    <= '0;
        end else if (start) begin
            len    <= CW'(clamp_bytes(start_dlc));
            active <= (clamp_bytes(start_dlc) != '0);
            cnt    <= '0;
        end else if (abort) begin
            active <= 1'b0;
        end else if (active) begin
            cnt <= cnt + CW'(1);
            if (cnt == len - CW'(1)) active <= 1'b0;
        end
    end

    assert_len_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
        active |-> (len != '0 && cnt < len));

    assert_stream_ends_R6: assert property (@(posedge clk) disable iff (rst)
        (active && last && !start) |=> !active);
endmodule

// File: rtl/can_tx_sched.sv
module can_tx_sched
    import can_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_init,
    input  logic [ADDR_W-1:0] cfg_start_addr,
    input  logic [CNT_W-1:0]  cfg_ded_num,
    input  logic [CNT_W-1:0]  cfg_pool_num,
    input  logic              cfg_queue_mode,
    input  logic [DLC_W-1:0]  cfg_field_bytes,
    input  logic              wr_ded_en,
    input  logic [IDX_W-1:0]  wr_ded_idx,
    input  logic              wr_pool_en,
    input  logic [ID_W-1:0]   wr_id,
    input  logic [DLC_W-1:0]  wr_dlc,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              req_en,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic              cancel_en,
    input  logic [IDX_W-1:0]  cancel_idx,
    input  logic              tx_start,
    input  logic              tx_done,
    output logic              sel_valid,
    output logic [IDX_W-1:0]  sel_idx,
    output logic [ADDR_W-1:0] sel_addr,
    output logic              byte_valid,
    output logic [7:0]        byte_data,
    output logic              byte_last,
    output logic              pool_full,
    output logic [CNT_W-1:0]  pool_level
);
    tx_cfg_t                     act, nxt_cfg;
    tx_elem_t                    ram [NELEM];
    logic [NELEM-1:0]            pending, cand, free_rel;
    logic [NELEM-1:0][ID_W-1:0]  ids;
    logic                        busy;
    logic [IDX_W-1:0]            cur_idx, put_rel, get_rel, push_abs;
    logic                        cfg_load, start_ok, done_ok, pop, cur_is_pool;
    logic                        req_ok, cancel_ok, pool_push, push_ok;
    tx_elem_t                    wr_elem;

    // ---------------- configuration capture ----------------
    always_comb begin
        nxt_cfg.start = cfg_start_addr;
        nxt_cfg.ded   = (int'(cfg_ded_num) > NELEM) ? CNT_W'(NELEM) : cfg_ded_num;
        nxt_cfg.pool  = (int'(cfg_pool_num) > NELEM - int'(nxt_cfg.ded))
                        ? CNT_W'(NELEM - int'(nxt_cfg.ded)) : cfg_pool_num;
        nxt_cfg.queue = cfg_queue_mode;
        nxt_cfg.field = clamp_bytes(cfg_field_bytes);
    end

    assign cfg_load = cfg_init && (pending == '0) && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            act <= '{start: '0, ded: '0, pool: '0, queue: 1'b0, field: DLC_W'(MAX_BYTES)};
        end else if (cfg_load) begin
            act <= nxt_cfg;
        end
    end

    // ---------------- candidate and free masks ----------------
    always_comb begin
        for (int i = 0; i < NELEM; i++) begin
            cand[i] = pending[i] &&
                      ((i < int'(act.ded)) ||
                       ((i >= int'(act.ded)) && (i < int'(act.ded) + int'(act.pool)) &&
                        (act.queue || (i == int'(act.ded) + int'(get_rel)))));
            ids[i] = ram[i].id;
        end
        for (int r = 0; r < NELEM; r++) begin
            free_rel[r] = (r < int'(act.pool)) && (int'(act.ded) + r < NELEM) &&
                          !pending[IDX_W'(int'(act.ded) + r)];
        end
    end

    can_tx_arb #(.N(NELEM), .ID_W(ID_W)) arb_i (
        .cand  (cand),
        .ids   (ids),
        .found (sel_valid),
        .win   (sel_idx)
    );

    assign sel_addr = act.start + ADDR_W'(sel_idx) * elem_words(act.field);

    // ---------------- pool bookkeeping ----------------
    assign cur_is_pool = int'(cur_idx) >= int'(act.ded);
    assign done_ok     = tx_done && busy;
    assign pop         = done_ok && cur_is_pool;
    assign pool_push   = wr_pool_en && !cfg_init;
    assign push_ok     = pool_push && !pool_full;
    assign push_abs    = IDX_W'(int'(act.ded) + int'(put_rel));

    can_tx_pool #(.N(NELEM)) pool_i (
        .clk      (clk),
        .rst      (rst),
        .load     (cfg_load),
        .size     (act.pool),
        .queue    (act.queue),
        .free_rel (free_rel),
        .push     (pool_push),
        .pop      (pop),
        .put_rel  (put_rel),
        .get_rel  (get_rel),
        .level    (pool_level),
        .full     (pool_full)
    );

    // ---------------- host requests and armed state ----------------
    assign start_ok  = tx_start && sel_valid && !busy;
    assign req_ok    = req_en && !cfg_init && (int'(req_idx) < int'(act.ded));
    assign cancel_ok = cancel_en && (int'(cancel_idx) < int'(act.ded)) &&
                       !(busy && cancel_idx == cur_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= '0;
            busy    <= 1'b0;
            cur_idx <= '0;
        end else begin
            logic [NELEM-1:0] p;
            p = pending;
            if (done_ok)   p[cur_idx]    = 1'b0;
            if (req_ok)    p[req_idx]    = 1'b1;
            if (cancel_ok) p[cancel_idx] = 1'b0;
            if (push_ok)   p[push_abs]   = 1'b1;
            pending <= p;
            if (start_ok) begin
                busy    <= 1'b1;
                cur_idx <= sel_idx;
            end else if (done_ok) begin
                busy <= 1'b0;
            end
        end
    end

    // ---------------- element store ----------------
    assign wr_elem = '{id: wr_id, dlc: wr_dlc, data: wr_data};

    always_ff @(posedge clk) begin
        if (wr_ded_en && int'(wr_ded_idx) < int'(act.ded)) ram[wr_ded_idx] <= wr_elem;
        if (push_ok) ram[push_abs] <= wr_elem;
    end

    // ---------------- byte stream ----------------
    can_tx_stream #(.NB(MAX_BYTES)) stream_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start_ok),
        .abort     (done_ok),
        .start_dlc (ram[sel_idx].dlc),
        .field     (act.field),
        .data      (ram[cur_idx].data),
        .valid     (byte_valid),
        .byte_out  (byte_data),
        .last      (byte_last)
    );

    // ---------------- assertions ----------------
    assert_sel_is_cand_R5: assert property (@(posedge clk) disable iff (rst)
        sel_valid |-> cand[sel_idx]);

    assert_done_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && tx_done && !req_en) |=> !pending[$past(cur_idx)]);

    assert_cfg_locked_R10: assert property (@(posedge clk) disable iff (rst)
        (pending != '0) |=> $stable(act));

    assert_stream_in_flight_R6: assert property (@(posedge clk) disable iff (rst)
        byte_valid |-> busy);

    assert_inflight_kept_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && !tx_done) |=> pending[$past(cur_idx)]);
endmodule

// File: tb/can_tx_sched_tb.sv
module can_tx_sched_tb_top;
    import can_tx_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic              cfg_init, cfg_queue_mode;
    logic [ADDR_W-1:0] cfg_start_addr;
    logic [CNT_W-1:0]  cfg_ded_num, cfg_pool_num;
    logic [DLC_W-1:0]  cfg_field_bytes;
    logic              wr_ded_en, wr_pool_en, req_en, cancel_en, tx_start, tx_done;
    logic [IDX_W-1:0]  wr_ded_idx, req_idx, cancel_idx;
    logic [ID_W-1:0]   wr_id;
    logic [DLC_W-1:0]  wr_dlc;
    logic [DATA_W-1:0] wr_data;
    logic              sel_valid, byte_valid, byte_last, pool_full;
    logic [IDX_W-1:0]  sel_idx;
    logic [ADDR_W-1:0] sel_addr;
    logic [7:0]        byte_data;
    logic [CNT_W-1:0]  pool_level;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;   // 125 MHz

    can_tx_sched dut_i (.*);

    // start, field, dlc, dedicated index
    localparam logic [27:0] VEC [6] = '{
        {16'h0000, 4'd8, 4'd8,  4'd0},
        {16'h0100, 4'd4, 4'd8,  4'd1},
        {16'h0200, 4'd0, 4'd3,  4'd2},
        {16'h0040, 4'd5, 4'd6,  4'd3},
        {16'h0010, 4'd8, 4'd12, 4'd1},
        {16'h0000, 4'd7, 4'd0,  4'd2}
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] pat(input int idx);
        logic [63:0] d;
        for (int k = 0; k < 8; k++) d[8*k +: 8] = {4'(idx), 4'(k)} ^ 8'h5A;
        return d;
    endfunction

    task automatic configure(input logic [15:0] st, input int ded, input int pool,
                             input bit q, input int fld);
        cfg_start_addr = st; cfg_ded_num = CNT_W'(ded); cfg_pool_num = CNT_W'(pool);
        cfg_queue_mode = q; cfg_field_bytes = DLC_W'(fld);
        cfg_init = 1'b1; step(); cfg_init = 1'b0;
    endtask

    task automatic write_ded(input int idx, input logic [10:0] id, input int dlc, input logic [63:0] d);
        wr_ded_en = 1'b1; wr_ded_idx = IDX_W'(idx); wr_id = id; wr_dlc = DLC_W'(dlc); wr_data = d;
        step(); wr_ded_en = 1'b0;
    endtask

    task automatic write_pool(input logic [10:0] id, input logic [7:0] b0);
        wr_pool_en = 1'b1; wr_id = id; wr_dlc = 4'd1; wr_data = {56'h0, b0};
        step(); wr_pool_en = 1'b0;
    endtask

    task automatic request(input int idx);
        req_en = 1'b1; req_idx = IDX_W'(idx); step(); req_en = 1'b0;
    endtask

    task automatic cancel(input int idx);
        cancel_en = 1'b1; cancel_idx = IDX_W'(idx); step(); cancel_en = 1'b0;
    endtask

    task automatic send_check(input string req, input int idx, input logic [7:0] b0, input bit chk_b0);
        chk(req, sel_valid, 1);
        chk(req, sel_idx, idx);
        tx_start = 1'b1; step(); tx_start = 1'b0;
        if (chk_b0) chk(req, byte_data, b0);
        tx_done = 1'b1; step(); tx_done = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_init = 0; cfg_queue_mode = 0; cfg_start_addr = '0;
        cfg_ded_num = '0; cfg_pool_num = '0; cfg_field_bytes = 4'd8;
        wr_ded_en = 0; wr_pool_en = 0; req_en = 0; cancel_en = 0; tx_start = 0; tx_done = 0;
        wr_ded_idx = '0; req_idx = '0; cancel_idx = '0; wr_id = '0; wr_dlc = '0; wr_data = '0;
        repeat (3) step();
        rst = 1'b0; step();

        // R12 reset state
        chk("R12 sel_valid", sel_valid, 0);
        chk("R12 byte_valid", byte_valid, 0);
        chk("R12 pool_level", pool_level, 0);
        chk("R12 pool_full", pool_full, 1);
        // R8 start with nothing selected
        tx_start = 1'b1; step(); tx_start = 1'b0;
        chk("R8 start ignored", byte_valid, 0);

        // table: addressing, explicit request, padding stream
        for (int v = 0; v < 6; v++) begin
            logic [15:0] st; int fld, dlc, idx, n, ew;
            logic [63:0] d;
            st = VEC[v][27:12]; fld = int'(VEC[v][11:8]); dlc = int'(VEC[v][7:4]); idx = int'(VEC[v][3:0]);
            d = pat(idx);
            configure(st, 4, 0, 0, fld);
            write_ded(idx, 11'h123, dlc, d);
            chk("R4 unarmed not selected", sel_valid, 0);
            request(idx);
            chk("R4 armed selected", sel_valid, 1);
            chk("R4 index", sel_idx, idx);
            ew = 2 + (((fld > 8 ? 8 : fld) + 3) / 4);
            chk("R1 address", sel_addr, 64'(st + 16'(idx * ew)));
            tx_start = 1'b1; step(); tx_start = 1'b0;
            n = (dlc > 8) ? 8 : dlc;
            for (int k = 0; k < n; k++) begin
                chk("R6 byte_valid", byte_valid, 1);
                chk("R6 byte_data", byte_data, (k < fld) ? 64'(d[8*k +: 8]) : 64'hCC);
                chk("R6 byte_last", byte_last, (k == n - 1) ? 1 : 0);
                step();
            end
            chk("R6 stream end", byte_valid, 0);
            tx_done = 1'b1; step(); tx_done = 1'b0;
            chk("R8 done clears", sel_valid, 0);
        end

        // R4 out-of-range and init-time requests ignored
        configure(16'h0, 2, 0, 0, 8);
        write_ded(1, 11'h0AA, 1, 64'h77);
        request(2);
        chk("R4 out of range request", sel_valid, 0);
        req_en = 1'b1; req_idx = 3'd1; cfg_init = 1'b1; step(); req_en = 1'b0; cfg_init = 1'b0;
        chk("R4 request during init", sel_valid, 0);
        request(1);
        send_check("R4 normal request", 1, 8'h77, 1);

        // R5 lowest identifier, tie to lower index
        configure(16'h0, 3, 0, 0, 8);
        write_ded(0, 11'h200, 1, 64'h1);
        write_ded(1, 11'h100, 1, 64'h2);
        write_ded(2, 11'h100, 1, 64'h3);
        request(0); request(1); request(2);
        send_check("R5 tie lower index", 1, 8'h2, 1);
        send_check("R5 tie second", 2, 8'h3, 1);
        send_check("R5 highest id last", 0, 8'h1, 1);
        chk("R5 empty", sel_valid, 0);

        // R9 cancel
        configure(16'h0, 2, 0, 0, 8);
        write_ded(0, 11'h010, 1, 64'h1);
        write_ded(1, 11'h020, 1, 64'h2);
        request(0); request(1);
        cancel(0);
        chk("R9 cancel idle buffer", sel_idx, 1);
        req_en = 1'b1; req_idx = 3'd0; cancel_en = 1'b1; cancel_idx = 3'd0; step();
        req_en = 1'b0; cancel_en = 1'b0;
        chk("R9 cancel beats request", sel_idx, 1);
        tx_start = 1'b1; step(); tx_start = 1'b0;
        cancel(1);
        chk("R9 in-flight kept", sel_valid, 1);
        tx_done = 1'b1; step(); tx_done = 1'b0;
        chk("R9 cleared by done", sel_valid, 0);

        // R2 write-order pool
        configure(16'h0, 1, 4, 0, 8);
        write_ded(0, 11'h040, 1, 64'h9);   // never armed
        write_pool(11'h050, 8'h11);
        write_pool(11'h050, 8'h22);
        write_pool(11'h010, 8'h33);
        chk("R7 level", pool_level, 3);
        send_check("R2 first pushed", 1, 8'h11, 1);
        send_check("R2 same id order", 2, 8'h22, 1);
        send_check("R2 lower id waits", 3, 8'h33, 1);
        chk("R2 empty", sel_valid, 0);

        // R3 queue pool
        configure(16'h0, 2, 3, 1, 8);
        write_pool(11'h300, 8'hA0);
        write_pool(11'h100, 8'hA1);
        write_pool(11'h200, 8'hA2);
        write_ded(0, 11'h150, 1, 64'hB0);
        request(0);
        send_check("R3 lowest id pool", 3, 8'hA1, 1);
        send_check("R5 dedicated competes", 0, 8'hB0, 1);
        write_pool(11'h050, 8'hA3);
        send_check("R3 lowest free slot", 3, 8'hA3, 1);
        send_check("R3 next", 4, 8'hA2, 1);
        send_check("R3 last", 2, 8'hA0, 1);
        chk("R3 empty", pool_level, 0);

        // R7 / R11 full pool and same-cycle push with done
        configure(16'h0, 0, 2, 0, 8);
        write_pool(11'h001, 8'hD1);
        write_pool(11'h002, 8'hD2);
        chk("R7 full flag", pool_full, 1);
        write_pool(11'h003, 8'hD3);
        chk("R7 refused", pool_level, 2);
        tx_start = 1'b1; step(); tx_start = 1'b0;
        tx_done = 1'b1; wr_pool_en = 1'b1; wr_id = 11'h004; wr_dlc = 4'd1; wr_data = 64'hD4;
        step(); tx_done = 1'b0; wr_pool_en = 1'b0;
        chk("R11 full push refused", pool_level, 1);
        chk("R7 not full", pool_full, 0);
        chk("R11 next is B", sel_idx, 1);
        tx_start = 1'b1; step(); tx_start = 1'b0;
        tx_done = 1'b1; wr_pool_en = 1'b1; wr_id = 11'h005; wr_data = 64'hD5;
        step(); tx_done = 1'b0; wr_pool_en = 1'b0;
        chk("R11 level held", pool_level, 1);
        send_check("R11 pushed message", 0, 8'hD5, 1);
        chk("R11 empty", pool_level, 0);

        // R10 configuration locked while armed
        configure(16'h0100, 1, 0, 0, 8);
        write_ded(0, 11'h011, 1, 64'hE1);
        request(0);
        chk("R10 base", sel_addr, 16'h0100);
        cfg_start_addr = 16'h0400; cfg_init = 1'b1; step();
        chk("R10 locked", sel_addr, 16'h0100);
        tx_start = 1'b1; step(); tx_start = 1'b0;
        tx_done = 1'b1; step(); tx_done = 1'b0;
        step();
        cfg_init = 1'b0;
        request(0);
        chk("R10 applied after idle", sel_addr, 16'h0400);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule